// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns the two wires of a low-speed USB differential pair into a stream of received bytes. It samples D+ and D- on the system clock at several samples per bit. While the bus is idle it watches for the sync field. It locks its bit phase to the J-to-K transitions of that field. It accepts the start of a packet only when one transition is followed by a second K bit.

Once locked, the block takes one sample per bit near the middle of the bit. It moves that sample point back to the middle on every data transition. Each bit is NRZI-decoded, stuffed bits are dropped, and the data bits are packed into bytes least significant bit first. Each byte comes out on a data bus with a single-cycle strobe.

A packet ends in one of three ways:
- A held SE0 gives an end-of-packet pulse.
- A packet longer than the configured byte limit gives an overflow pulse.
- A run of seven ones gives a stuffing-error pulse.

After an overflow or a stuffing error, the block discards the rest of the packet up to the next SE0.

Top module: `usb_ls_rx`

## Requirements
- R1: Line states are decoded from {D+, D-}: J is (0,1), K is (1,0), SE0 is (0,0), and (1,1) is treated as J. After reset every output is low until a packet has been received.
- R2: A packet starts only when a J-to-K edge is followed by K at the middle of the next bit. A J-to-K edge followed by J is rejected, and the search resumes at the next J-to-K edge.
- R3: After a rejected edge, if no new J-to-K edge arrives within SEARCH_CLKS clocks, the block returns to idle. It must then see a full bit time of J before it searches again. A later valid packet is still received.
- R4: NRZI decoding gives 1 when a bit has the same line state as the previous bit and 0 when it differs. The first data bit is compared against the final K of the sync field.
- R5: Data bits are packed least significant bit first. Each completed byte appears on rx_data together with a one-clock rx_valid pulse.
- R6: After six consecutive decoded ones, the next bit is discarded. The trailing one of the sync field counts toward these six.
- R7: A seventh consecutive one, where a stuffed zero was due, gives a one-clock rx_stuff_err pulse and aborts the packet. No further bytes and no rx_eop follow for that packet.
- R8: rx_eop is a one-clock pulse after SE0 has held for OVERSAMPLE clocks. Data bits that do not complete a byte are discarded.
- R9: A packet may deliver at most BUF_BYTES bytes. The byte after that is not delivered; rx_overflow pulses once instead, and the packet is aborted without rx_eop. The next packet is received normally.
- R10: Because of the resynchronisation on transitions, bits of OVERSAMPLE-1 or OVERSAMPLE+1 clocks, mixed among nominal bits, are decoded correctly.
- R11: SE0 on an idle bus (keep-alive) produces no byte and no rx_eop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, OVERSAMPLE times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-clock strobe qualifying rx_data |
| rx_eop | output | 1 | One-clock end-of-packet pulse |
| rx_overflow | output | 1 | One-clock pulse: packet exceeded BUF_BYTES |
| rx_stuff_err | output | 1 | One-clock pulse: bit-stuffing violation |

## Verification
The bench builds the receiver with OVERSAMPLE=8, BUF_BYTES=4 and SEARCH_CLKS=64.

The four-byte limit makes overflow, and the exact-limit boundary, reachable with packets only a few bytes long. The 64-clock search window is shorter than a run of twelve J bits, so the search timeout can be forced within a single transfer.

Every one of the 256 byte values is sent as its own packet. Each packet uses one of three bit-period patterns: nominal, stretched, or shortened. Every NRZI and stuffing combination inside a byte is therefore met, with and without phase drift.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

  // Line state encoded as {D+, D-}
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [2:0] {
    ST_IDLE,     // qualify a bit time of J
    ST_ARMED,    // wait for first J-to-K edge
    ST_CONFIRM,  // check for second K one bit later
    ST_HUNT,     // rejected edge, bounded search for the next one
    ST_DATA,     // locked, one sample per bit
    ST_DRAIN     // aborted packet, wait for SE0
  } rx_state_t;

endpackage

// File: rtl/usb_ls_line_sync.sv
module usb_ls_line_sync
  import usb_ls_rx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  dp,
  input  logic  dm,
  output line_t line_now,
  output line_t line_prev
);

  logic [STAGES-1:0] dp_sh;
  logic [STAGES-1:0] dm_sh;
  logic [1:0]        pair;
  line_t             cls;

  always_comb begin
    pair = {dp_sh[STAGES-1], dm_sh[STAGES-1]};
    cls  = (pair == 2'b11) ? LN_J : line_t'(pair);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_sh     <= '0;
      dm_sh     <= '1;
      line_now  <= LN_J;
      line_prev <= LN_J;
    end else begin
      dp_sh     <= {dp_sh[STAGES-2:0], dp};
      dm_sh     <= {dm_sh[STAGES-2:0], dm};
      line_now  <= cls;
      line_prev <= line_now;
    end
  end

endmodule

// File: rtl/usb_ls_bit_clk.sv
module usb_ls_bit_clk
  import usb_ls_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 8,
  parameter int SEARCH_CLKS = 96
) (
  input  logic  clk,
  input  logic  rst,
  input  line_t line_now,
  input  line_t line_prev,
  input  logic  abort,
  output logic  sync_ok,
  output logic  bit_stb,
  output line_t bit_line,
  output logic  eop_stb
);

  localparam int PW = $clog2(OVERSAMPLE);
  localparam int CW = $clog2(SEARCH_CLKS + 2 * OVERSAMPLE);
  localparam logic [PW-1:0] PH_MID    = PW'(OVERSAMPLE / 2);
  localparam logic [PW-1:0] PH_LAST   = PW'(OVERSAMPLE - 1);
  localparam logic [PW-1:0] PH_RESUME = PW'(OVERSAMPLE / 2 + 1);
  localparam logic [PW-1:0] PH_ONE    = PW'(1);
  localparam logic [CW-1:0] C_BIT     = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] C_CHECK   = CW'(OVERSAMPLE + OVERSAMPLE / 2);
  localparam logic [CW-1:0] C_WIN     = CW'(SEARCH_CLKS - 1);
  localparam logic [CW-1:0] C_ONE     = CW'(1);

  rx_state_t       st;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   ph;
  logic [PW-1:0]   se0_cnt;
  logic            jk_edge;
  logic            data_edge;
  logic            se0_done;
  logic            now_jk;
  logic            prev_jk;

  always_comb begin
    now_jk    = (line_now == LN_J) || (line_now == LN_K);
    prev_jk   = (line_prev == LN_J) || (line_prev == LN_K);
    jk_edge   = (line_now == LN_K) && (line_prev == LN_J);
    data_edge = now_jk && prev_jk && (line_now != line_prev);
    se0_done  = (line_now == LN_SE0) && (se0_cnt == PH_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      se0_cnt <= '0;
    end else if (line_now == LN_SE0) begin
      if (se0_cnt != PH_LAST) se0_cnt <= se0_cnt + 1'b1;
    end else begin
      se0_cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      ph       <= '0;
      sync_ok  <= 1'b0;
      bit_stb  <= 1'b0;
      bit_line <= LN_J;
      eop_stb  <= 1'b0;
    end else begin
      sync_ok <= 1'b0;
      bit_stb <= 1'b0;
      eop_stb <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (line_now == LN_J) begin
            if (cnt == C_BIT) begin
              st  <= ST_ARMED;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            cnt <= '0;
          end
        end
        ST_ARMED: begin
          if (jk_edge) begin
            st  <= ST_CONFIRM;
            cnt <= C_ONE;
          end
        end
        ST_CONFIRM: begin
          if (cnt == C_CHECK) begin
            cnt <= '0;
            if (line_now == LN_K) begin
              st      <= ST_DATA;
              sync_ok <= 1'b1;
              ph      <= PH_RESUME;
            end else if (line_now == LN_J) begin
              st <= ST_HUNT;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HUNT: begin
          if (jk_edge) begin
            st  <= ST_CONFIRM;
            cnt <= C_ONE;
          end else if (line_now == LN_SE0 || cnt == C_WIN) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (abort) begin
            st <= ST_DRAIN;
          end else if (se0_done) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            eop_stb <= 1'b1;
          end else begin
            if (data_edge)          ph <= PH_ONE;
            else if (ph == PH_LAST) ph <= '0;
            else                    ph <= ph + 1'b1;
            if (!data_edge && ph == PH_MID) begin
              bit_stb  <= 1'b1;
              bit_line <= line_now;
            end
          end
        end
        ST_DRAIN: begin
          if (se0_done) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end
        end
        default: begin
          st  <= ST_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/usb_ls_byte_asm.sv
module usb_ls_byte_asm
  import usb_ls_rx_pkg::*;
#(
  parameter int BUF_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_ok,
  input  logic       bit_stb,
  input  line_t      bit_line,
  input  logic       eop_stb,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_eop,
  output logic       rx_overflow,
  output logic       rx_stuff_err
);

  localparam int BW = $clog2(BUF_BYTES + 1);
  localparam logic [BW-1:0] B_LIMIT   = BW'(BUF_BYTES);
  localparam logic [2:0]    RUN_LIMIT = 3'd6;

  line_t         prev_line;
  logic [2:0]    ones;
  logic [2:0]    nbits;
  logic [BW-1:0] nbytes;
  logic [7:0]    shreg;
  logic          live;
  logic          dec;
  logic [7:0]    next_sh;

  always_comb begin
    dec     = (bit_line == prev_line);
    next_sh = {dec, shreg[7:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_line    <= LN_K;
      ones         <= '0;
      nbits        <= '0;
      nbytes       <= '0;
      shreg        <= '0;
      live         <= 1'b0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_eop       <= 1'b0;
      rx_overflow  <= 1'b0;
      rx_stuff_err <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      rx_eop       <= 1'b0;
      rx_overflow  <= 1'b0;
      rx_stuff_err <= 1'b0;
      if (sync_ok) begin
        prev_line <= LN_K;
        ones      <= 3'd1;
        nbits     <= '0;
        nbytes    <= '0;
        live      <= 1'b1;
      end else if (eop_stb) begin
        rx_eop <= live;
        live   <= 1'b0;
      end else if (bit_stb && live && bit_line != LN_SE0) begin
        prev_line <= bit_line;
        if (ones == RUN_LIMIT) begin
          if (dec) begin
            rx_stuff_err <= 1'b1;
            live         <= 1'b0;
          end else begin
            ones <= '0;
          end
        end else begin
          ones  <= dec ? ones + 1'b1 : 3'd0;
          shreg <= next_sh;
          nbits <= nbits + 1'b1;
          if (nbits == 3'd7) begin
            if (nbytes == B_LIMIT) begin
              rx_overflow <= 1'b1;
              live        <= 1'b0;
            end else begin
              rx_data  <= next_sh;
              rx_valid <= 1'b1;
              nbytes   <= nbytes + 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 8,
  parameter int BUF_BYTES   = 8,
  parameter int SEARCH_CLKS = 96,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       usb_dp,
  input  logic       usb_dm,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_eop,
  output logic       rx_overflow,
  output logic       rx_stuff_err
);

  line_t line_now;
  line_t line_prev;
  line_t bit_line;
  logic  sync_ok;
  logic  bit_stb;
  logic  eop_stb;
  logic  abort;

  assign abort = rx_overflow | rx_stuff_err;

  usb_ls_line_sync #(.STAGES(SYNC_STAGES)) u_line (
    .clk       (clk),
    .rst       (rst),
    .dp        (usb_dp),
    .dm        (usb_dm),
    .line_now  (line_now),
    .line_prev (line_prev)
  );

  usb_ls_bit_clk #(
    .OVERSAMPLE  (OVERSAMPLE),
    .SEARCH_CLKS (SEARCH_CLKS)
  ) u_bitclk (
    .clk       (clk),
    .rst       (rst),
    .line_now  (line_now),
    .line_prev (line_prev),
    .abort     (abort),
    .sync_ok   (sync_ok),
    .bit_stb   (bit_stb),
    .bit_line  (bit_line),
    .eop_stb   (eop_stb)
  );

  usb_ls_byte_asm #(.BUF_BYTES(BUF_BYTES)) u_bytes (
    .clk          (clk),
    .rst          (rst),
    .sync_ok      (sync_ok),
    .bit_stb      (bit_stb),
    .bit_line     (bit_line),
    .eop_stb      (eop_stb),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_eop       (rx_eop),
    .rx_overflow  (rx_overflow),
    .rx_stuff_err (rx_stuff_err)
  );

endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk #(
  parameter int BUF_BYTES = 8
) (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic rx_eop,
  input logic rx_overflow,
  input logic rx_stuff_err
);

  localparam int SW = $clog2(BUF_BYTES + 2) + 1;

  logic [SW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (rx_eop || rx_overflow || rx_stuff_err) seen <= '0;
    else if (rx_valid) seen <= seen + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rx_valid && !rx_eop && !rx_overflow && !rx_stuff_err);

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8
  eop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_eop |=> !rx_eop);

  // R7
  end_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_eop, rx_overflow, rx_stuff_err}));

  // R9
  byte_limit_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (seen < SW'(BUF_BYTES)));

endmodule

bind usb_ls_rx usb_ls_rx_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rx_valid     (rx_valid),
  .rx_eop       (rx_eop),
  .rx_overflow  (rx_overflow),
  .rx_stuff_err (rx_stuff_err)
);

// File: tb/usb_ls_rx_test.sv
module usb_ls_rx_test;

  localparam int OS  = 8;
  localparam int BUF = 4;
  localparam int WIN = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dp  = 1'b0;
  logic       dm  = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, rx_eop, rx_overflow, rx_stuff_err;

  always #4 clk = ~clk;

  usb_ls_rx #(.OVERSAMPLE(OS), .BUF_BYTES(BUF), .SEARCH_CLKS(WIN)) uut (
    .clk(clk), .rst(rst), .usb_dp(dp), .usb_dm(dm),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_eop(rx_eop),
    .rx_overflow(rx_overflow), .rx_stuff_err(rx_stuff_err)
  );

  int n_chk = 0;
  int n_err = 0;
  int lv_q[$];          // 0 = K, 1 = J, 2 = SE0
  int cur_lv;
  int ones;
  logic [7:0] got[$];
  logic [7:0] exp_b[$];
  int n_eop, n_ovf, n_serr;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) got.push_back(rx_data);
      if (rx_eop) n_eop++;
      if (rx_overflow) n_ovf++;
      if (rx_stuff_err) n_serr++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    got.delete(); exp_b.delete();
    n_eop = 0; n_ovf = 0; n_serr = 0;
  endtask

  task automatic put_sync();
    lv_q.push_back(0); lv_q.push_back(1); lv_q.push_back(0); lv_q.push_back(1);
    lv_q.push_back(0); lv_q.push_back(1); lv_q.push_back(0); lv_q.push_back(0);
    cur_lv = 0;
    ones   = 1;
  endtask

  task automatic put_bit(input int b);
    if (b == 0) begin cur_lv = 1 - cur_lv; ones = 0; end
    else ones++;
    lv_q.push_back(cur_lv);
    if (ones == 6) begin
      cur_lv = 1 - cur_lv;
      lv_q.push_back(cur_lv);
      ones = 0;
    end
  endtask

  task automatic put_byte(input logic [7:0] v, input bit expect_it);
    for (int i = 0; i < 8; i++) put_bit(int'(v[i]));
    if (expect_it) exp_b.push_back(v);
  endtask

  task automatic put_end();
    lv_q.push_back(2); lv_q.push_back(2);
    lv_q.push_back(1); lv_q.push_back(1); lv_q.push_back(1);
  endtask

  // mode 0: nominal, 1: every 4th bit one clock long, 2: one clock short
  task automatic drive(input int mode);
    for (int i = 0; i < lv_q.size(); i++) begin
      int len = OS;
      if (mode == 1 && i % 4 == 3) len = OS + 1;
      if (mode == 2 && i % 4 == 3) len = OS - 1;
      @(negedge clk);
      dp = (lv_q[i] == 0);
      dm = (lv_q[i] == 1);
      repeat (len - 1) @(negedge clk);
    end
    @(negedge clk);
    dp = 1'b0; dm = 1'b1;
    lv_q.delete();
    repeat (24) @(negedge clk);
  endtask

  task automatic check_bytes(input string req, input string what);
    check(got.size() == exp_b.size(), req, {what, " byte count"}, got.size(), exp_b.size());
    if (got.size() == exp_b.size())
      for (int i = 0; i < exp_b.size(); i++)
        check(got[i] == exp_b[i], req, {what, " byte"}, int'(got[i]), int'(exp_b[i]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!rx_valid && !rx_eop && !rx_overflow && !rx_stuff_err, "R1", "outputs after reset",
          int'({rx_valid, rx_eop, rx_overflow, rx_stuff_err}), 0);
    repeat (24) @(negedge clk);

    // R4 R5 R8 R10: every byte value, three bit-period patterns
    for (int v = 0; v < 256; v++) begin
      clear_mon();
      put_sync(); put_byte(8'(v), 1'b1); put_end();
      drive(v % 3);
      check_bytes("R4 R5", "sweep");
      check(n_eop == 1, "R8", "sweep eop count", n_eop, 1);
    end

    // R6 stuffing across byte boundaries, sync one counted
    clear_mon();
    put_sync(); put_byte(8'hFF, 1'b1); put_byte(8'hFF, 1'b1); put_byte(8'h7E, 1'b1); put_end();
    drive(0);
    check_bytes("R6", "stuffed run");
    check(n_eop == 1, "R6", "stuffed run eop", n_eop, 1);
    clear_mon();
    put_sync(); put_byte(8'h3F, 1'b1); put_byte(8'hFC, 1'b1); put_end();
    drive(1);
    check_bytes("R6", "stuff after sync");

    // R10 drift with long runs and dense transitions
    for (int m = 1; m < 3; m++) begin
      clear_mon();
      put_sync(); put_byte(8'hFF, 1'b1); put_byte(8'h00, 1'b1); put_byte(8'hFF, 1'b1); put_end();
      drive(m);
      check_bytes("R10", "drifting bits");
      check(n_eop == 1, "R10", "drifting eop", n_eop, 1);
    end

    // R9 exactly the limit
    clear_mon();
    put_sync();
    put_byte(8'h12, 1'b1); put_byte(8'h34, 1'b1); put_byte(8'h56, 1'b1); put_byte(8'h78, 1'b1);
    put_end();
    drive(0);
    check_bytes("R9", "at limit");
    check(n_ovf == 0 && n_eop == 1, "R9", "at limit ovf/eop", n_ovf * 10 + n_eop, 1);

    // R9 beyond the limit
    clear_mon();
    put_sync();
    put_byte(8'hA1, 1'b1); put_byte(8'hB2, 1'b1); put_byte(8'hC3, 1'b1); put_byte(8'hD4, 1'b1);
    put_byte(8'hE5, 1'b0); put_byte(8'hF6, 1'b0);
    put_end();
    drive(0);
    check_bytes("R9", "overflow");
    check(n_ovf == 1, "R9", "overflow pulses", n_ovf, 1);
    check(n_eop == 0, "R9", "no eop after overflow", n_eop, 0);
    clear_mon();
    put_sync(); put_byte(8'h5A, 1'b1); put_end();
    drive(0);
    check_bytes("R9", "packet after overflow");

    // R7 seven ones without a stuffed zero
    clear_mon();
    put_sync();
    for (int i = 0; i < 8; i++) lv_q.push_back(0);
    put_end();
    drive(0);
    check(n_serr == 1, "R7", "stuff error pulses", n_serr, 1);
    check(got.size() == 0 && n_eop == 0, "R7", "bytes+eop after error", got.size() + n_eop, 0);
    clear_mon();
    put_sync(); put_byte(8'hC6, 1'b1); put_end();
    drive(0);
    check_bytes("R7", "packet after stuff error");

    // R8 partial byte discarded
    clear_mon();
    put_sync(); put_byte(8'h3C, 1'b1);
    put_bit(1); put_bit(0); put_bit(1); put_bit(0);
    put_end();
    drive(0);
    check_bytes("R8", "partial tail");
    check(n_eop == 1, "R8", "partial tail eop", n_eop, 1);

    // R11 keep-alive SE0 on idle bus
    clear_mon();
    put_end();
    drive(0);
    check(got.size() == 0 && n_eop == 0, "R11", "keep-alive outputs", got.size() + n_eop, 0);

    // R2 R3 rejected edge, long J past the window, then a real packet
    clear_mon();
    lv_q.push_back(0);
    for (int i = 0; i < 12; i++) lv_q.push_back(1);
    put_sync(); put_byte(8'hA5, 1'b1); put_end();
    drive(0);
    check_bytes("R2 R3", "after false edge");
    check(n_eop == 1, "R3", "after false edge eop", n_eop, 1);

    // R2 lone K-J pair with no following packet gives nothing
    clear_mon();
    lv_q.push_back(0); lv_q.push_back(1); lv_q.push_back(1); lv_q.push_back(1);
    drive(0);
    check(got.size() == 0 && n_eop == 0 && n_serr == 0, "R2", "lone edge outputs",
          got.size() + n_eop + n_serr, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule